// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter with a programmable clock divider in front of it and a single compare channel behind it. A divider counter runs on every clock while the timer is enabled; each time it reaches the programmed divide value it returns to zero and lets the main counter step by one. The main counter is compared against a programmed value on every step. When a step lands on that value, the block latches a sticky match flag. Depending on three independent action bits, it can also drive a level interrupt, load zero into the counter in place of the compared value, and drop its own enable so that counting halts.

Software reaches the block through a single-cycle register bus. Writes complete on the clock edge where select and write are high. Reads are combinational from the current address. A control register starts and stops counting and can hold both counters at zero. The match flag is cleared by writing a one to it. The counter may also be loaded directly, which allows fast moves to any point in its range.

Top module: `mtmr_top`

## Requirements
- R1: Register offsets are: match flag 0x000, control 0x004, counter 0x008, divide value 0x00C, action bits 0x014, compare value 0x018, source mode 0x070. A read of any other offset returns zero, and every mapped register except the flag reads back what was written.
- R2: Control bit 0 enables counting. While it is 0, the counter holds its value, and writing 0 to control halts a running timer.
- R3: While control bit 1 is 1, both the divider counter and the main counter are held at zero, whatever the state of bit 0. After release, the first step comes a full divide period later.
- R4: With divide value D and the timer enabled, the counter steps once every D+1 clocks. With D = 0 it steps on every clock.
- R5: Flag bit 0 sets on the step that makes the counter equal the compare value, and stays set until a write with bit 0 = 1 to offset 0x000. Writing 0 there has no effect.
- R6: With action bit 1 set, the step that would produce the compare value loads zero instead.
- R7: With action bit 2 set, a match clears control bit 0 on the same edge, so counting stops. The flag stays set while the timer is stopped.
- R8: The interrupt output is high exactly when the match flag is set and action bit 0 is 1.
- R9: With no action bits set, the counter runs through its whole range and wraps from all ones to zero. A compare value of zero still matches on that wrap.
- R10: The 2-bit source mode register stores any value. Every value counts the internal clock, so counting speed is unchanged.
- R11: A write to offset 0x008 loads the counter with the written value. A held control bit 1 takes priority over this load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt: match flag AND action bit 0 |

## Verification
The match function is tried with seven setups that differ in divide value, compare value and action bits. Comparing the pure free-run case with the divided case isolates the divider's period. Running the same compare value with no actions, reset only and stop only shows that each action bit acts alone, and combining reset with stop shows that both take effect on one edge. The interrupt-only case separates the flag from the irq pin. Directed cases then cover the held reset of a partly advanced divider, a counter load near all ones that wraps into a zero compare value, the write-one-to-clear flag, and readback of the mode register and of unmapped offsets.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
   localparam int unsigned BUS_AW = 12;
   localparam int unsigned BUS_DW = 32;

   localparam logic [BUS_AW-1:0] OFS_FLAG = 12'h000;
   localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h004;
   localparam logic [BUS_AW-1:0] OFS_CNT  = 12'h008;
   localparam logic [BUS_AW-1:0] OFS_DIV  = 12'h00C;
   localparam logic [BUS_AW-1:0] OFS_ACT  = 12'h014;
   localparam logic [BUS_AW-1:0] OFS_CMP  = 12'h018;
   localparam logic [BUS_AW-1:0] OFS_MODE = 12'h070;

   localparam int unsigned CTRL_EN   = 0;
   localparam int unsigned CTRL_HOLD = 1;

   localparam int unsigned ACT_IRQ  = 0;
   localparam int unsigned ACT_ZERO = 1;
   localparam int unsigned ACT_STOP = 2;
   localparam int unsigned ACT_W    = 3;
   localparam int unsigned MODE_W   = 2;

   typedef struct packed {
      logic stop;
      logic zero;
      logic irq;
   } act_t;
endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
   parameter int unsigned PRE_W        = 32,
   parameter bit          HAS_PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             hold_i,
   input  logic [PRE_W-1:0] div_i,
   output logic             tick_o
);
   generate
      if (PRE_W < 1 || PRE_W > 32) begin : g_bad_width
         $error("mtmr_prescaler: PRE_W must lie in 1..32");
      end

      if (HAS_PRESCALE) begin : g_div
         logic [PRE_W-1:0] pc_q;
         logic             run;
         logic             wrap;

         assign run    = en_i && !hold_i;
         assign wrap   = run && (pc_q == div_i);
         assign tick_o = wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_q <= '0;
            end else if (hold_i) begin
               pc_q <= '0;
            end else if (wrap) begin
               pc_q <= '0;
            end else if (run) begin
               pc_q <= pc_q + 1'b1;
            end
         end

         // R4
         pc_tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> (pc_q == '0));

         // R3
         pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i |=> (pc_q == '0));
      end else begin : g_nodiv
         assign tick_o = en_i && !hold_i;
      end
   endgenerate
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             hold_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             zero_on_hit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] step;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("mtmr_counter: CNT_W must lie in 2..32");
      end
   endgenerate

   assign step  = cnt_q + 1'b1;
   assign hit_o = tick_i && !hold_i && !load_i && (step == cmp_i);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hold_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick_i) begin
         if (hit_o && zero_on_hit_i) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= step;
         end
      end
   end

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (cnt_q == '0));

   // R2
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !hold_i && !load_i) |=> $stable(cnt_q));

   // R6
   cnt_zero_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && zero_on_hit_i) |=> (cnt_q == '0));

   // R11
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !hold_i) |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/mtmr_regfile.sv
module mtmr_regfile
   import mtmr_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PRE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic              hit_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              en_o,
   output logic              hold_o,
   output logic [PRE_W-1:0]  div_o,
   output logic [CNT_W-1:0]  cmp_o,
   output act_t              act_o,
   output logic              flag_o,
   output logic              load_o,
   output logic [CNT_W-1:0]  load_val_o
);
   logic              we;
   logic              wr_flag;
   logic              wr_ctrl;
   logic              clr_flag;
   logic              stop_req;
   logic              en_q;
   logic              hold_q;
   logic [PRE_W-1:0]  div_q;
   logic [CNT_W-1:0]  cmp_q;
   act_t              act_q;
   logic [MODE_W-1:0] mode_q;
   logic              flag_q;

   assign we       = bus_sel && bus_wr;
   assign wr_flag  = we && (bus_addr == OFS_FLAG);
   assign wr_ctrl  = we && (bus_addr == OFS_CTRL);
   assign clr_flag = wr_flag && bus_wdata[0];
   assign stop_req = hit_i && act_q.stop;

   assign load_o     = we && (bus_addr == OFS_CNT);
   assign load_val_o = bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         hold_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q   <= bus_wdata[CTRL_EN];
         hold_q <= bus_wdata[CTRL_HOLD];
      end else if (stop_req) begin
         en_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         cmp_q  <= '0;
         act_q  <= '0;
         mode_q <= '0;
      end else if (we) begin
         unique case (bus_addr)
            OFS_DIV:  div_q  <= bus_wdata[PRE_W-1:0];
            OFS_CMP:  cmp_q  <= bus_wdata[CNT_W-1:0];
            OFS_ACT:  act_q  <= act_t'(bus_wdata[ACT_W-1:0]);
            OFS_MODE: mode_q <= bus_wdata[MODE_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit_i) begin
         flag_q <= 1'b1;
      end else if (clr_flag) begin
         flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_FLAG: bus_rdata[0]           = flag_q;
         OFS_CTRL: bus_rdata[1:0]         = {hold_q, en_q};
         OFS_CNT:  bus_rdata[CNT_W-1:0]   = cnt_i;
         OFS_DIV:  bus_rdata[PRE_W-1:0]   = div_q;
         OFS_ACT:  bus_rdata[ACT_W-1:0]   = act_q;
         OFS_CMP:  bus_rdata[CNT_W-1:0]   = cmp_q;
         OFS_MODE: bus_rdata[MODE_W-1:0]  = mode_q;
         default:  bus_rdata              = '0;
      endcase
   end

   assign en_o   = en_q;
   assign hold_o = hold_q;
   assign div_o  = div_q;
   assign cmp_o  = cmp_q;
   assign act_o  = act_q;
   assign flag_o = flag_q;

   // R7
   stop_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !wr_ctrl) |=> !en_q);

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> flag_q);

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_flag) |=> flag_q);
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
   import mtmr_pkg::*;
#(
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned PRE_W        = 32,
   parameter bit          HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              irq
);
   logic             en;
   logic             hold;
   logic [PRE_W-1:0] div;
   logic [CNT_W-1:0] cmp;
   act_t             act;
   logic             flag;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt;
   logic             hit;
   logic             tick;

   mtmr_regfile #(.CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .hit_i      (hit),
      .cnt_i      (cnt),
      .en_o       (en),
      .hold_o     (hold),
      .div_o      (div),
      .cmp_o      (cmp),
      .act_o      (act),
      .flag_o     (flag),
      .load_o     (load),
      .load_val_o (load_val)
   );

   mtmr_prescaler #(.PRE_W(PRE_W), .HAS_PRESCALE(HAS_PRESCALE)) pre_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .hold_i (hold),
      .div_i  (div),
      .tick_o (tick)
   );

   mtmr_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick),
      .hold_i        (hold),
      .load_i        (load),
      .load_val_i    (load_val),
      .cmp_i         (cmp),
      .zero_on_hit_i (act.zero),
      .cnt_o         (cnt),
      .hit_o         (hit)
   );

   assign irq = flag && act.irq;

   // R8
   irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && act.irq) |=> irq);

   // R2
   halted_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load && !hold) |=> $stable(cnt));
endmodule

// File: tb/mtmr_top_tb_top.sv
module mtmr_top_tb_top;
   import mtmr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   mtmr_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // divide, compare, actions, wait edges, expected count, flag, enable, irq
   localparam int NV = 7;
   localparam int V_DIV [NV] = '{0, 3, 0, 0, 0, 1, 2};
   localparam int V_CMP [NV] = '{100, 100, 5, 5, 5, 3, 4};
   localparam int V_ACT [NV] = '{0, 0, 0, 2, 4, 6, 1};
   localparam int V_N   [NV] = '{10, 20, 10, 12, 10, 20, 30};
   localparam int V_CNT [NV] = '{10, 5, 10, 2, 5, 0, 10};
   localparam int V_FLG [NV] = '{0, 0, 1, 1, 1, 1, 1};
   localparam int V_EN  [NV] = '{1, 1, 1, 1, 0, 0, 1};
   localparam int V_IRQ [NV] = '{0, 0, 0, 0, 0, 0, 1};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // called at a falling edge; write lands on the next rising edge
   task automatic bw(input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic br(input logic [11:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] c0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      br(OFS_CTRL, v); chk("R2 reset control", v, 0);
      br(OFS_CNT, v);  chk("R2 reset counter", v, 0);
      br(OFS_FLAG, v); chk("R5 reset flag", v, 0);
      chk("R8 reset irq", {31'd0, irq}, 0);

      for (int i = 0; i < NV; i++) begin
         bw(OFS_CTRL, 32'h2);
         bw(OFS_DIV, V_DIV[i]);
         bw(OFS_CMP, V_CMP[i]);
         bw(OFS_ACT, V_ACT[i]);
         bw(OFS_FLAG, 32'h1);
         bw(OFS_CTRL, 32'h1);
         edges(V_N[i]);
         // R4 R6 R7 R9 counter value per vector
         br(OFS_CNT, v);  chk($sformatf("R4/R6 vec%0d count", i), v, V_CNT[i]);
         br(OFS_FLAG, v); chk($sformatf("R5 vec%0d flag", i), v, V_FLG[i]);
         br(OFS_CTRL, v); chk($sformatf("R7 vec%0d enable", i), v, V_EN[i]);
         chk($sformatf("R8 vec%0d irq", i), {31'd0, irq}, V_IRQ[i]);
         if (i == 4) begin
            edges(10);
            br(OFS_FLAG, v); chk("R7 flag kept while stopped", v, 1);
            br(OFS_CNT, v);  chk("R7 counter halted after stop", v, 5);
         end
      end

      // R5 write of 0 ignored, write of 1 clears
      bw(OFS_FLAG, 32'h0);
      br(OFS_FLAG, v); chk("R5 zero write ignored", v, 1);
      chk("R8 irq still high", {31'd0, irq}, 1);
      bw(OFS_FLAG, 32'h1);
      br(OFS_FLAG, v); chk("R5 one write clears", v, 0);
      chk("R8 irq low after clear", {31'd0, irq}, 0);

      // R2 disable halts counting
      bw(OFS_CTRL, 32'h0);
      br(OFS_CNT, c0);
      edges(5);
      br(OFS_CNT, v); chk("R2 counter halted", v, c0);

      // R3 held reset zeroes counter and a partly advanced divider
      bw(OFS_CTRL, 32'h2);
      bw(OFS_DIV, 32'h3);
      bw(OFS_ACT, 32'h0);
      bw(OFS_CMP, 32'hFFFF_0000);
      bw(OFS_CTRL, 32'h1);
      edges(6);
      br(OFS_CNT, v); chk("R4 divide by four", v, 1);
      bw(OFS_CTRL, 32'h3);
      edges(5);
      br(OFS_CNT, v); chk("R3 held at zero with enable", v, 0);
      bw(OFS_CTRL, 32'h1);
      edges(3);
      br(OFS_CNT, v); chk("R3 divider restarted from zero", v, 0);
      edges(1);
      br(OFS_CNT, v); chk("R3 first step after full period", v, 1);

      // R11 held reset beats a counter load
      bw(OFS_CTRL, 32'h2);
      bw(OFS_CNT, 32'h55);
      br(OFS_CNT, v); chk("R11 load blocked by hold", v, 0);

      // R9 wrap through all ones into zero compare value
      bw(OFS_CTRL, 32'h0);
      bw(OFS_CMP, 32'h0);
      bw(OFS_DIV, 32'h0);
      bw(OFS_FLAG, 32'h1);
      bw(OFS_CNT, 32'hFFFF_FFFE);
      br(OFS_CNT, v); chk("R11 counter load", v, 32'hFFFF_FFFE);
      bw(OFS_CTRL, 32'h1);
      edges(3);
      br(OFS_CNT, v);  chk("R9 wrapped count", v, 1);
      br(OFS_FLAG, v); chk("R9 match on wrap", v, 1);
      br(OFS_CTRL, v); chk("R9 still enabled", v, 1);

      // R10 source mode stored, counting unchanged
      bw(OFS_MODE, 32'h3);
      br(OFS_MODE, v); chk("R10 mode readback", v, 3);
      br(OFS_CNT, c0);
      edges(4);
      br(OFS_CNT, v); chk("R10 counting unchanged", v, c0 + 4);

      // R1 readback and unmapped offsets
      bw(OFS_CTRL, 32'h0);
      bw(OFS_CMP, 32'hA5A5_1234);
      br(OFS_CMP, v);  chk("R1 compare readback", v, 32'hA5A5_1234);
      bw(OFS_DIV, 32'h77);
      br(OFS_DIV, v);  chk("R1 divide readback", v, 32'h77);
      br(OFS_ACT, v);  chk("R1 action readback", v, 0);
      br(12'h010, v);  chk("R1 unmapped 0x010", v, 0);
      br(12'h0FC, v);  chk("R1 unmapped 0x0FC", v, 0);

      summary();
   end
endmodule